// File: doc/BRIEF.md
# Serial LED Shifter for Drive Bays

This block turns per-port drive status indications into a three-wire serial stream (clock, load, data) for an external LED controller. Each port has three indications: activity, locate and fault. A host sends a port index and a 32-bit status message over a valid/ready channel. The block decodes the message into the three indication bits, writes them into a stored pattern at the slot that the port maps to, and then sends the whole pattern as one frame.

A frame has four parts, in this order: a programmable number of idle clocks, one clock with load high, three data bits per configured port sent least significant first, and a programmable number of trailing idle clocks. Each serial clock is high for `HALF_CYC` system clocks and then low for `HALF_CYC` system clocks. The port count, the two idle counts and the port-to-slot map are plain configuration inputs. The block samples them when it accepts a request.

Back-pressure: `req_ready` is high only when no frame is in flight. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While a frame runs, the requester must hold its request stable until that edge.

Top module: `sgpio_led_shifter`

## Requirements
- R1: After reset, `sgpio_clk`, `sgpio_load` and `sgpio_data` are all high, `busy` is low, `req_ready` is high, and every bit of the stored pattern is zero.
- R2: After a request is accepted at a clock edge, the frame starts in the next system cycle. Each serial cycle keeps `sgpio_clk` high for `HALF_CYC` system cycles and then low for `HALF_CYC` system cycles.
- R3: The frame opens with `cfg_pre_clks` serial cycles in which load and data are both low. A count of zero skips this part.
- R4: Right after the opening idle cycles, load is high for exactly one serial cycle, and data is low during that cycle.
- R5: Next come 3×N data cycles, where N is `cfg_num_ports` clamped to `MAX_PORTS`. The data cycle with index i carries pattern bit i, so bit 0 goes first. When N is 2, only 6 bits are sent.
- R6: The frame closes with `cfg_post_clks` serial cycles in which load and data are both low. A count of zero skips this part.
- R7: Port p maps to slot s = `cfg_slot_map[3p+2:3p]`. Activity is stored at pattern bit 3s, locate at bit 3s+1 and fault at bit 3s+2. Bits of other slots keep their values.
- R8: The activity bit is set when message bit 20 or bit 21 is set. The locate bit follows message bit 19 and the fault bit follows message bit 22. Each indication is cleared when its source bit or bits are clear.
- R9: A message whose slot field, bits 15:8, is at least `SLOT_LIMIT` is still taken by the handshake. It makes `err` high for the one cycle after acceptance, leaves the pattern unchanged and starts no frame.
- R10: `busy` is high from the cycle after acceptance through the last low phase. `req_ready` is low while `busy` is high, so a held request waits. `done` is high for exactly one cycle, the first cycle after the frame.
- R11: After a frame, all three serial lines stay low until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (no frame in flight) |
| req_port | input | $clog2(MAX_PORTS) | Port the message refers to |
| req_msg | input | 32 | Status message (indications and slot field) |
| cfg_num_ports | input | $clog2(MAX_PORTS+1) | Number of ports in the frame |
| cfg_pre_clks | input | CNT_W | Idle serial cycles before load |
| cfg_post_clks | input | CNT_W | Idle serial cycles after the data |
| cfg_slot_map | input | MAX_PORTS*$clog2(MAX_PORTS) | Port-to-slot map, 3 bits per port |
| sgpio_clk | output | 1 | Serial clock line |
| sgpio_load | output | 1 | Serial load line |
| sgpio_data | output | 1 | Serial data line |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse after a frame |
| err | output | 1 | One-cycle pulse after a rejected request |

## Verification
The bench builds the block with `HALF_CYC` = 2, `SLOT_LIMIT` = 4 and `MAX_PORTS` = 8. With these values a full 24-bit frame with idle clocks takes about a hundred system cycles, so the bench can compare every phase of every serial cycle against its own model. A slot limit of 4 puts the rejection boundary (3 is accepted, 4 is rejected) inside an 8-bit field that is easy to reach. Eight ports let the bench test remapping to the top slot, clamping of an oversized port count, and a request held back during a frame whose slot is shifted late in that frame.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

  // Message bit positions that the decoder depends on.
  localparam int MSG_ACT_A   = 20;
  localparam int MSG_ACT_B   = 21;
  localparam int MSG_LOC     = 19;
  localparam int MSG_FLT     = 22;
  localparam int MSG_SLOT_LO = 8;
  localparam int MSG_SLOT_HI = 15;

  // Order matches the in-slot bit order: act at +0, loc at +1, flt at +2.
  typedef struct packed {
    logic flt;
    logic loc;
    logic act;
  } led_ind_t;

  function automatic led_ind_t decode_msg(input logic [31:0] msg);
    led_ind_t r;
    r.act = msg[MSG_ACT_A] | msg[MSG_ACT_B];
    r.loc = msg[MSG_LOC];
    r.flt = msg[MSG_FLT];
    return r;
  endfunction

endpackage

// File: rtl/sgpio_pattern_store.sv
module sgpio_pattern_store #(
  parameter int MAX_PORTS = 8,
  localparam int SLOT_W = $clog2(MAX_PORTS),
  localparam int PW = 3 * MAX_PORTS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  sgpio_pkg::led_ind_t ind_i,
  output logic [PW-1:0]       pat_o
);

  for (genvar s = 0; s < MAX_PORTS; s++) begin : g_slot
    logic [2:0] ind_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ind_q <= '0;
      end else if (upd_i && (slot_i == SLOT_W'(s))) begin
        ind_q <= ind_i;
      end
    end
    assign pat_o[3*s +: 3] = ind_q;
  end

endmodule

// File: rtl/sgpio_frame_seq.sv
module sgpio_frame_seq #(
  parameter int HALF_CYC = 6250,
  parameter int CNT_W    = 8,
  parameter int PW       = 24,
  parameter int NB_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pre_i,
  input  logic [CNT_W-1:0] post_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic [PW-1:0]    pat_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             sload_o,
  output logic             sdata_o
);

  localparam int PH_W    = $clog2(2 * HALF_CYC);
  localparam int TOT_MAX = 2 * ((1 << CNT_W) - 1) + 1 + PW;
  localparam int K_W     = $clog2(TOT_MAX + 1);
  localparam int IDX_W   = $clog2(PW);
  localparam int EXT     = 1 << IDX_W;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF_CYC - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_CYC);

  logic            run_q, rest_q, done_q;
  logic [PH_W-1:0] ph_q;
  logic [K_W-1:0]  k_q, pre_q, dend_q, last_q;

  // Divider phase and serial-cycle index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rest_q <= 1'b1;
      done_q <= 1'b0;
      ph_q   <= '0;
      k_q    <= '0;
      pre_q  <= '0;
      dend_q <= '0;
      last_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q  <= 1'b1;
        ph_q   <= '0;
        k_q    <= '0;
        pre_q  <= K_W'(pre_i);
        dend_q <= K_W'(pre_i) + K_W'(nbits_i);
        last_q <= K_W'(pre_i) + K_W'(nbits_i) + K_W'(post_i);
      end else if (run_q) begin
        if (ph_q == PH_LAST) begin
          ph_q <= '0;
          if (k_q == last_q) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
            rest_q <= 1'b0;
          end else begin
            k_q <= k_q + K_W'(1);
          end
        end else begin
          ph_q <= ph_q + PH_W'(1);
        end
      end
    end
  end

  logic [K_W-1:0] off;
  logic [EXT-1:0] pat_ext;
  logic           in_data;
  logic           unused_off_hi;

  assign off           = k_q - pre_q - K_W'(1);
  assign pat_ext       = EXT'(pat_i);
  assign in_data       = (k_q > pre_q) && (k_q <= dend_q);
  assign unused_off_hi = ^off[K_W-1:IDX_W];

  always_comb begin
    if (run_q) begin
      sclk_o  = (ph_q < PH_HALF);
      sload_o = (k_q == pre_q);
      sdata_o = in_data ? pat_ext[off[IDX_W-1:0]] : 1'b0;
    end else begin
      sclk_o  = rest_q;
      sload_o = rest_q;
      sdata_o = rest_q;
    end
  end

  assign busy_o = run_q;
  assign done_o = done_q;

endmodule

// File: rtl/sgpio_led_shifter.sv
module sgpio_led_shifter #(
  parameter int MAX_PORTS  = 8,
  parameter int HALF_CYC   = 6250,
  parameter int CNT_W      = 8,
  parameter int SLOT_LIMIT = 15,
  localparam int SLOT_W = $clog2(MAX_PORTS),
  localparam int NP_W   = $clog2(MAX_PORTS + 1),
  localparam int PW     = 3 * MAX_PORTS,
  localparam int NB_W   = $clog2(PW + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [SLOT_W-1:0]           req_port,
  input  logic [31:0]                 req_msg,
  input  logic [NP_W-1:0]             cfg_num_ports,
  input  logic [CNT_W-1:0]            cfg_pre_clks,
  input  logic [CNT_W-1:0]            cfg_post_clks,
  input  logic [MAX_PORTS*SLOT_W-1:0] cfg_slot_map,
  output logic                        sgpio_clk,
  output logic                        sgpio_load,
  output logic                        sgpio_data,
  output logic                        busy,
  output logic                        done,
  output logic                        err
);

  import sgpio_pkg::*;

  localparam logic [8:0] LIMIT = 9'(SLOT_LIMIT);

  logic              accept, bad_slot, good;
  logic              err_q;
  logic [SLOT_W-1:0] map_a [MAX_PORTS];
  logic [SLOT_W-1:0] slot;
  logic [NP_W-1:0]   n_eff;
  logic [NB_W-1:0]   nbits;
  logic [PW-1:0]     pat;

  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_map
    assign map_a[p] = cfg_slot_map[p*SLOT_W +: SLOT_W];
  end

  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;
  assign bad_slot  = {1'b0, req_msg[MSG_SLOT_HI:MSG_SLOT_LO]} >= LIMIT;
  assign good      = accept & ~bad_slot;
  assign slot      = map_a[req_port];
  assign n_eff     = (cfg_num_ports > NP_W'(MAX_PORTS)) ? NP_W'(MAX_PORTS) : cfg_num_ports;
  assign nbits     = NB_W'(n_eff) * NB_W'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= accept & bad_slot;
  end
  assign err = err_q;

  sgpio_pattern_store #(.MAX_PORTS(MAX_PORTS)) store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (good),
    .slot_i (slot),
    .ind_i  (decode_msg(req_msg)),
    .pat_o  (pat)
  );

  sgpio_frame_seq #(
    .HALF_CYC (HALF_CYC),
    .CNT_W    (CNT_W),
    .PW       (PW),
    .NB_W     (NB_W)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (good),
    .pre_i   (cfg_pre_clks),
    .post_i  (cfg_post_clks),
    .nbits_i (nbits),
    .pat_i   (pat),
    .busy_o  (busy),
    .done_o  (done),
    .sclk_o  (sgpio_clk),
    .sload_o (sgpio_load),
    .sdata_o (sgpio_data)
  );

endmodule

// File: rtl/sgpio_led_shifter_chk.sv
module sgpio_led_shifter_chk #(
  parameter int HALF_CYC   = 6250,
  parameter int SLOT_LIMIT = 15
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_msg,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        sgpio_clk,
  input logic        sgpio_load,
  input logic        sgpio_data
);

  localparam int HW = $clog2(HALF_CYC + 2) + 1;

  logic          bad_slot;
  logic          busy_d, clk_d;
  logic [HW-1:0] hold_q;

  assign bad_slot = int'(req_msg[15:8]) >= SLOT_LIMIT;

  // Length of the current run of a constant serial clock level while busy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_d <= 1'b0;
      clk_d  <= 1'b1;
      hold_q <= '0;
    end else begin
      busy_d <= busy;
      clk_d  <= sgpio_clk;
      if (!busy)                                hold_q <= '0;
      else if (busy_d && (sgpio_clk == clk_d)) begin
        if (hold_q != '1)                       hold_q <= hold_q + HW'(1);
      end else                                  hold_q <= HW'(1);
    end
  end

  a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (hold_q <= HW'(HALF_CYC)));

  a_r4_load_data_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sgpio_load) |-> !sgpio_data);

  a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_slot) |=> (err && !busy));

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !bad_slot) |=> (busy && sgpio_clk && !err));

  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r10_busy_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  a_r11_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sgpio_clk && !sgpio_load && !sgpio_data));

endmodule

bind sgpio_led_shifter sgpio_led_shifter_chk #(
  .HALF_CYC   (HALF_CYC),
  .SLOT_LIMIT (SLOT_LIMIT)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_msg    (req_msg),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .sgpio_clk  (sgpio_clk),
  .sgpio_load (sgpio_load),
  .sgpio_data (sgpio_data)
);

// File: tb/sgpio_led_shifter_tb_top.sv
module sgpio_led_shifter_tb_top;

  localparam int NPORT = 8;
  localparam int H     = 2;
  localparam int LIM   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_port = '0;
  logic [31:0] req_msg = '0;
  logic [3:0]  cfg_num_ports = 4'd8;
  logic [7:0]  cfg_pre_clks = '0;
  logic [7:0]  cfg_post_clks = '0;
  logic [23:0] cfg_slot_map;
  logic        sgpio_clk, sgpio_load, sgpio_data, busy, done, err;

  int n_cmp = 0;
  int n_bad = 0;
  int map_tb [NPORT];
  logic [23:0] exp_pat = '0;

  always #4 clk = ~clk;

  sgpio_led_shifter #(
    .MAX_PORTS  (NPORT),
    .HALF_CYC   (H),
    .CNT_W      (8),
    .SLOT_LIMIT (LIM)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_port      (req_port),
    .req_msg       (req_msg),
    .cfg_num_ports (cfg_num_ports),
    .cfg_pre_clks  (cfg_pre_clks),
    .cfg_post_clks (cfg_post_clks),
    .cfg_slot_map  (cfg_slot_map),
    .sgpio_clk     (sgpio_clk),
    .sgpio_load    (sgpio_load),
    .sgpio_data    (sgpio_data),
    .busy          (busy),
    .done          (done),
    .err           (err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pack_map();
    for (int p = 0; p < NPORT; p++) cfg_slot_map[3*p +: 3] = 3'(map_tb[p]);
  endtask

  // Independent model of the message decode and slot placement (R7, R8).
  task automatic model_update(input int port, input logic [31:0] msg);
    int s;
    s = map_tb[port];
    exp_pat[3*s]   = msg[20] | msg[21];
    exp_pat[3*s+1] = msg[19];
    exp_pat[3*s+2] = msg[22];
  endtask

  // Called at a falling edge. Sends one request and checks its whole frame.
  task automatic run_frame(input int port, input logic [31:0] msg, input int pre,
                           input int post, input int np, input bit pend,
                           input int pport, input logic [31:0] pmsg);
    int n_eff, nb, total;
    pack_map();
    cfg_pre_clks  = 8'(pre);
    cfg_post_clks = 8'(post);
    cfg_num_ports = 4'(np);
    req_port  = 3'(port);
    req_msg   = msg;
    req_valid = 1'b1;
    chk(req_ready === 1'b1, "R10", "ready before request", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    model_update(port, msg);
    n_eff = (np > NPORT) ? NPORT : np;
    nb    = 3 * n_eff;
    total = pre + 1 + nb + post;
    for (int k = 0; k < total; k++) begin
      int miss = 0;
      logic [4:0] av = '0, ev = '0;
      string rq;
      if (k < pre)          rq = "R3";
      else if (k == pre)    rq = "R4";
      else if (k <= pre+nb) rq = "R5";
      else                  rq = "R6";
      for (int p = 0; p < 2*H; p++) begin
        logic [4:0] a, e;
        e[4] = (p < H);
        e[3] = (k == pre);
        e[2] = (k > pre && k <= pre + nb) ? exp_pat[k-pre-1] : 1'b0;
        e[1] = 1'b1;
        e[0] = 1'b0;
        a = {sgpio_clk, sgpio_load, sgpio_data, busy, req_ready};
        if (a !== e && miss == 0) begin av = a; ev = e; end
        if (a !== e) miss++;
        if (pend && k == 1 && p == 0) begin
          req_valid = 1'b1;
          req_port  = 3'(pport);
          req_msg   = pmsg;
        end
        @(negedge clk);
      end
      chk(miss == 0, miss == 0 ? rq : (ev[4] != av[4] ? "R2" : rq),
          $sformatf("serial cycle %0d {clk,load,data,busy,ready}", k), int'(av), int'(ev));
    end
    chk(done === 1'b1 && busy === 1'b0, "R10", "done pulse after frame",
        int'({done, busy}), 2);
    chk({sgpio_clk, sgpio_load, sgpio_data} === 3'b000, "R11", "lines at rest",
        int'({sgpio_clk, sgpio_load, sgpio_data}), 0);
    if (!pend) begin
      @(negedge clk);
      chk(done === 1'b0 && {sgpio_clk, sgpio_load, sgpio_data} === 3'b000, "R11",
          "rest one cycle later", int'({done, sgpio_clk, sgpio_load, sgpio_data}), 0);
    end
  endtask

  task automatic t_reset();
    chk({sgpio_clk, sgpio_load, sgpio_data} === 3'b111, "R1", "lines after reset",
        int'({sgpio_clk, sgpio_load, sgpio_data}), 7);
    chk(busy === 1'b0 && req_ready === 1'b1 && done === 1'b0 && err === 1'b0, "R1",
        "flags after reset", int'({busy, req_ready, done, err}), 4);
  endtask

  // R1 pattern cleared, R8 activity through bit 20, idle clocks on both sides.
  task automatic t_basic();
    run_frame(0, 32'h0010_0000, 2, 1, 8, 1'b0, 0, '0);
  endtask

  // R8 all three indications, R3/R6 with zero idle counts.
  task automatic t_all_ind_no_idle();
    run_frame(3, 32'h0068_0000, 0, 0, 8, 1'b0, 0, '0);
  endtask

  // R7 remapped slot.
  task automatic t_remap();
    map_tb[2] = 7;
    map_tb[7] = 2;
    run_frame(2, 32'h0040_0000, 1, 2, 8, 1'b0, 0, '0);
  endtask

  // R8 clearing, R5 with only two ports in the frame.
  task automatic t_clear_short();
    run_frame(0, 32'h0000_0000, 3, 0, 2, 1'b0, 0, '0);
  endtask

  // R9 rejected slot field, then the highest accepted field value.
  task automatic t_reject();
    req_port  = 3'd5;
    req_msg   = 32'h0040_0400;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err === 1'b1 && busy === 1'b0, "R9", "err after rejected slot",
        int'({err, busy}), 2);
    @(negedge clk);
    chk(err === 1'b0 && busy === 1'b0 && sgpio_clk === 1'b0, "R9", "no frame after reject",
        int'({err, busy, sgpio_clk}), 0);
    run_frame(5, 32'h0008_0300, 1, 1, 8, 1'b0, 0, '0);
  endtask

  // R10 request held off during a frame, then taken; R5 port count clamped.
  task automatic t_backpressure();
    run_frame(1, 32'h0020_0000, 1, 1, 8, 1'b1, 6, 32'h0040_0000);
    run_frame(6, 32'h0040_0000, 0, 0, 12, 1'b0, 0, '0);
  endtask

  initial begin
    for (int p = 0; p < NPORT; p++) map_tb[p] = p;
    pack_map();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_all_ind_no_idle();
    t_remap();
    t_clear_short();
    t_reject();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule